// File: doc/BRIEF.md
# Audio DMA Host Register Bank

This block is the host-facing register bank of a three-channel audio DMA engine (two playback channels, one capture channel). It decodes an 8-bit byte-addressed I/O window and accepts byte, half-word and word accesses. It holds the control, status, page, codec and serial-control registers. It folds per-channel pending interrupt flags into a summary status bit and a single interrupt line.

Accesses into the upper 16-byte slice of the window are banked. The page register supplies bits 11:8 of the effective address, so the per-channel frame pointer and frame count registers of the downstream channel blocks are reached through that slice. Those registers and the sample counters live outside this block. Here they exist only as decoded strobes with a channel select, a field code and byte-lane enables, and their read data returns through an input port. Read data is combinational and right-aligned to the access width. Writes commit on the rising clock edge of the request cycle.

A channel's pending flag is set by a one-cycle pulse from its channel block, and only while that channel's interrupt enable is on. The flag is cleared only when software turns that enable off.

Top module: `audio_regbank`

## Requirements
- R1: After reset, word reads return control 0x00000001, status 0x00000060, page 0, codec 0 and serial control 0, and irq_o is low.
- R2: Control (0x00), codec (0x10) and serial control (0x20) take byte writes (size 0) to any lane and half-word writes (size 1) to either half, merging only the addressed lanes; word writes (size 2) replace the whole register.
- R3: Reads return the addressed register shifted down by 8 times the low two address bits and masked to the access width (8, 16 or 32 bits).
- R4: When addr_i[7:4] is 3, the effective address is {page, addr_i}, with the 4-bit page register in bits 11:8; otherwise bits 11:8 are zero. The page register sits at 0x0C and keeps only bits 3:0 of a written word.
- R5: Aligned accesses to effective word addresses 0x024/0x028/0x02C assert ext_wr_o or ext_rd_o with field 0 (sample count) for channels 0/1/2. The frame registers use field 1 (frame address) and field 2 (frame count): 0xC30/0xC34 for channel 0, 0xC38/0xC3C for channel 1, 0xD30/0xD34 for channel 2. The channel appears one-hot on ext_chan_o (bit k for channel k), the lanes on ext_be_o, and the write data lane-shifted on ext_wdata_o. A read returns ext_rdata_i shifted and masked per R3.
- R6: Reads of unmapped effective addresses, and misaligned accesses, return all ones of the access width (zero above it). Such writes change no register, and misaligned ones raise no strobe.
- R7: The status register (0x04) is read-only; writes to it leave every register unchanged.
- R8: A pulse on set_pend_i[k] sets pending flag k (status bit 2 for channel 0, bit 1 for channel 1, bit 0 for capture channel 2... see R9) only when that channel's serial-control enable bit is 1; otherwise it is ignored.
- R9: The pending flags for channels 0, 1 and 2 are status bits 2, 1 and 0. Status bit 31 and irq_o equal the OR of the three flags, and status bits 6:5 always read 1.
- R10: A serial-control write that turns enable bit 8 (channel 0), 9 (channel 1) or 10 (channel 2) from 1 to 0 clears that channel's pending flag. A set pulse in the same cycle loses to the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 0 byte, 1 half-word, 2 word |
| addr_i | input | 8 | Byte address within the window |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, right-aligned, combinational |
| set_pend_i | input | 3 | Per-channel pending set pulses |
| irq_o | output | 1 | Interrupt line, OR of pending flags |
| ext_wr_o | output | 1 | Write strobe to channel register blocks |
| ext_rd_o | output | 1 | Read strobe to channel register blocks |
| ext_chan_o | output | 3 | One-hot channel select |
| ext_field_o | output | 2 | 0 sample count, 1 frame address, 2 frame count |
| ext_be_o | output | 4 | Byte-lane enables |
| ext_wdata_o | output | 32 | Lane-shifted write data |
| ext_rdata_i | input | 32 | Word read data from channel register blocks |

## Verification
The read path is swept over every byte address at all three widths under several page values. This separates in-window banking from flat decoding, and mapped registers and external strobes from unmapped or misaligned holes. Lane merging is tried with distinct byte patterns written to each lane and half of control, codec and serial control, so any lane swap or over-wide write shows up in the word readback. The interrupt path is driven with set pulses while enables are off, while they are on, and in the same cycle as an enable clear. This tells gating, aggregation and clear priority apart.

// File: rtl/areg_pkg.sv
package areg_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_STAT, SEL_PAGE, SEL_CODEC, SEL_SCTL, SEL_EXT
  } sel_e;

  localparam logic [31:0] CTL_RST    = 32'h0000_0001;
  localparam logic [31:0] STAT_FIXED = 32'h0000_0060;
  localparam int          EN_LSB     = 8;
  localparam int          NCH_DEF    = 3;
  localparam logic [3:0]  BANK_NIB   = 4'h3;

  localparam logic [1:0]  FLD_SCNT = 2'd0;
  localparam logic [1:0]  FLD_FADR = 2'd1;
  localparam logic [1:0]  FLD_FCNT = 2'd2;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_v;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/areg_decode.sv
module areg_decode
  import areg_pkg::*;
#(
  parameter int AW = 8,
  parameter int PW = 4
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [PW-1:0] page_i,
  output sel_e          sel_o,
  output logic          aligned_o,
  output logic [3:0]    be_o,
  output logic [2:0]    chan_o,
  output logic [1:0]    field_o
);
  localparam int EW = AW + PW;

  logic [EW-1:0] eff;
  logic [EW-1:0] word;

  always_comb begin
    eff  = (addr_i[AW-1:4] == BANK_NIB) ? {page_i, addr_i} : {{PW{1'b0}}, addr_i};
    word = {eff[EW-1:2], 2'b00};

    case (size_i)
      2'd0: begin aligned_o = 1'b1;                 be_o = 4'b0001 << addr_i[1:0]; end
      2'd1: begin aligned_o = ~addr_i[0];           be_o = 4'b0011 << addr_i[1:0]; end
      2'd2: begin aligned_o = (addr_i[1:0] == 2'b00); be_o = 4'b1111;              end
      default: begin aligned_o = 1'b0;              be_o = 4'b0000;                end
    endcase

    sel_o   = SEL_NONE;
    chan_o  = 3'b000;
    field_o = FLD_SCNT;
    case (word)
      EW'(12'h000): sel_o = SEL_CTL;
      EW'(12'h004): sel_o = SEL_STAT;
      EW'(12'h00C): sel_o = SEL_PAGE;
      EW'(12'h010): sel_o = SEL_CODEC;
      EW'(12'h020): sel_o = SEL_SCTL;
      EW'(12'h024): begin sel_o = SEL_EXT; chan_o = 3'b001; field_o = FLD_SCNT; end
      EW'(12'h028): begin sel_o = SEL_EXT; chan_o = 3'b010; field_o = FLD_SCNT; end
      EW'(12'h02C): begin sel_o = SEL_EXT; chan_o = 3'b100; field_o = FLD_SCNT; end
      EW'(12'hC30): begin sel_o = SEL_EXT; chan_o = 3'b001; field_o = FLD_FADR; end
      EW'(12'hC34): begin sel_o = SEL_EXT; chan_o = 3'b001; field_o = FLD_FCNT; end
      EW'(12'hC38): begin sel_o = SEL_EXT; chan_o = 3'b010; field_o = FLD_FADR; end
      EW'(12'hC3C): begin sel_o = SEL_EXT; chan_o = 3'b010; field_o = FLD_FCNT; end
      EW'(12'hD30): begin sel_o = SEL_EXT; chan_o = 3'b100; field_o = FLD_FADR; end
      EW'(12'hD34): begin sel_o = SEL_EXT; chan_o = 3'b100; field_o = FLD_FCNT; end
      default: ;
    endcase
  end
endmodule

// File: rtl/areg_irq.sv
module areg_irq #(
  parameter int NCH = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] fall_i,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             pend_o[k] <= 1'b0;
      else if (fall_i[k])      pend_o[k] <= 1'b0;  // clear beats a same-cycle set
      else if (set_i[k] && en_i[k]) pend_o[k] <= 1'b1;
    end
  end

  assign irq_o = |pend_o;
endmodule

// File: rtl/audio_regbank.sv
module audio_regbank
  import areg_pkg::*;
#(
  parameter int AW  = 8,
  parameter int PW  = 4,
  parameter int DW  = 32,
  parameter int NCH = NCH_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [1:0]     size_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  input  logic [NCH-1:0] set_pend_i,
  output logic           irq_o,
  output logic           ext_wr_o,
  output logic           ext_rd_o,
  output logic [2:0]     ext_chan_o,
  output logic [1:0]     ext_field_o,
  output logic [3:0]     ext_be_o,
  output logic [DW-1:0]  ext_wdata_o,
  input  logic [DW-1:0]  ext_rdata_i
);
  localparam int SHW = $clog2(DW);

  sel_e           sel;
  logic           aligned;
  logic [3:0]     be;
  logic [SHW-1:0] sh;
  logic [DW-1:0]  wd_lane, wmask, rsrc, stat;
  logic           acc_ok, wr;

  logic [DW-1:0]  ctl_q, codec_q, sctl_q, sctl_nxt, page_w;
  logic [PW-1:0]  page_q;
  logic [NCH-1:0] pend_q, en_fall;

  areg_decode #(.AW(AW), .PW(PW)) u_dec (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .page_i   (page_q),
    .sel_o    (sel),
    .aligned_o(aligned),
    .be_o     (be),
    .chan_o   (ext_chan_o),
    .field_o  (ext_field_o)
  );

  assign sh      = {addr_i[1:0], 3'b000};
  assign wd_lane = wdata_i << sh;
  assign acc_ok  = req_i & aligned;
  assign wr      = acc_ok & we_i;

  assign sctl_nxt = lane_merge(sctl_q, wd_lane, be);
  assign page_w   = lane_merge({{(DW-PW){1'b0}}, page_q}, wd_lane, be);

  for (genvar k = 0; k < NCH; k++) begin : g_fall
    assign en_fall[k] = wr && (sel == SEL_SCTL) && sctl_q[EN_LSB+k] && !sctl_nxt[EN_LSB+k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= CTL_RST;
      codec_q <= '0;
      sctl_q  <= '0;
      page_q  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_CTL:   ctl_q   <= lane_merge(ctl_q, wd_lane, be);
        SEL_CODEC: codec_q <= lane_merge(codec_q, wd_lane, be);
        SEL_SCTL:  sctl_q  <= sctl_nxt;
        SEL_PAGE:  page_q  <= page_w[PW-1:0];
        default: ;
      endcase
    end
  end

  areg_irq #(.NCH(NCH)) u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (set_pend_i),
    .en_i  (sctl_q[EN_LSB +: NCH]),
    .fall_i(en_fall),
    .pend_o(pend_q),
    .irq_o (irq_o)
  );

  // channel 0 -> bit 2, channel 2 -> bit 0
  always_comb begin
    stat = STAT_FIXED;
    stat[DW-1] = irq_o;
    for (int k = 0; k < NCH; k++) stat[NCH-1-k] = pend_q[k];
  end

  always_comb begin
    case (size_i)
      2'd0:    wmask = DW'(8'hFF);
      2'd1:    wmask = DW'(16'hFFFF);
      default: wmask = '1;
    endcase
    case (sel)
      SEL_CTL:   rsrc = ctl_q;
      SEL_STAT:  rsrc = stat;
      SEL_PAGE:  rsrc = {{(DW-PW){1'b0}}, page_q};
      SEL_CODEC: rsrc = codec_q;
      SEL_SCTL:  rsrc = sctl_q;
      SEL_EXT:   rsrc = ext_rdata_i;
      default:   rsrc = '1;
    endcase
    rdata_o = aligned ? ((rsrc >> sh) & wmask) : wmask;
  end

  assign ext_wr_o    = wr & (sel == SEL_EXT);
  assign ext_rd_o    = acc_ok & ~we_i & (sel == SEL_EXT);
  assign ext_be_o    = be;
  assign ext_wdata_o = wd_lane;
endmodule

// File: rtl/areg_chk.sv
module areg_chk #(
  parameter int DW  = 32,
  parameter int PW  = 4,
  parameter int NCH = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [NCH-1:0] set_pend_i,
  input logic           irq_o,
  input logic           ext_wr_o,
  input logic           ext_rd_o,
  input logic [2:0]     ext_chan_o,
  input logic [DW-1:0]  ctl_q,
  input logic [DW-1:0]  sctl_q,
  input logic [PW-1:0]  page_q,
  input logic [NCH-1:0] pend_q
);
  for (genvar k = 0; k < NCH; k++) begin : g_a
    AST_CLEAR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sctl_q[8+k]) |-> !pend_q[k]);                                   // R10
    AST_SET_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[k]) |-> ($past(sctl_q[8+k]) && $past(set_pend_i[k])));   // R8
  end

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|set_pend_i));                                   // R9
  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(req_i && we_i));                                 // R10
  AST_EXT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_wr_o || ext_rd_o) |-> ($countones(ext_chan_o) == 1));              // R5
  AST_EXT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_o |-> (req_i && we_i));                                          // R5
  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(ctl_q));                              // R2
  AST_PAGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && we_i) |-> $stable(page_q));                             // R4
endmodule

bind audio_regbank areg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .set_pend_i(set_pend_i),
  .irq_o     (irq_o),
  .ext_wr_o  (ext_wr_o),
  .ext_rd_o  (ext_rd_o),
  .ext_chan_o(ext_chan_o),
  .ctl_q     (ctl_q),
  .sctl_q    (sctl_q),
  .page_q    (page_q),
  .pend_q    (pend_q)
);

// File: tb/audio_regbank_tb_top.sv
`timescale 1ns/1ps
module audio_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  set_pend = 3'b000;
  logic        irq;
  logic        ext_wr, ext_rd;
  logic [2:0]  ext_chan;
  logic [1:0]  ext_field;
  logic [3:0]  ext_be;
  logic [31:0] ext_wdata;
  logic [31:0] ext_rdata = 32'hA5C3_0F96;

  int checks = 0, errors = 0;

  logic [31:0] ctl_m = 32'h1, codec_m = 0, sctl_m = 0;
  logic [3:0]  page_m = 0;
  logic [2:0]  pend_m = 0;

  always #2.5 clk = ~clk;

  audio_regbank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .set_pend_i(set_pend),
    .irq_o(irq), .ext_wr_o(ext_wr), .ext_rd_o(ext_rd), .ext_chan_o(ext_chan),
    .ext_field_o(ext_field), .ext_be_o(ext_be), .ext_wdata_o(ext_wdata),
    .ext_rdata_i(ext_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h size=%0d act=%h exp=%h", tag, addr, size, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [11:0] eff_of(input logic [7:0] a);
    return (a[7:4] == 4'h3) ? {page_m, a} : {4'h0, a};
  endfunction

  function automatic bit is_al(input logic [7:0] a, input logic [1:0] sz);
    return (sz == 0) || (sz == 1 && !a[0]) || (sz == 2 && a[1:0] == 0);
  endfunction

  function automatic logic [31:0] stat_m();
    return 32'h60 | {29'b0, pend_m[0], pend_m[1], pend_m[2]} | {(|pend_m), 31'b0};
  endfunction

  // {valid, chan one-hot, field}
  function automatic logic [5:0] ext_of(input logic [11:0] w);
    case (w)
      12'h024: return {1'b1, 3'b001, 2'd0};
      12'h028: return {1'b1, 3'b010, 2'd0};
      12'h02C: return {1'b1, 3'b100, 2'd0};
      12'hC30: return {1'b1, 3'b001, 2'd1};
      12'hC34: return {1'b1, 3'b001, 2'd2};
      12'hC38: return {1'b1, 3'b010, 2'd1};
      12'hC3C: return {1'b1, 3'b010, 2'd2};
      12'hD30: return {1'b1, 3'b100, 2'd1};
      12'hD34: return {1'b1, 3'b100, 2'd2};
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic [1:0] sz);
    logic [11:0] w;
    logic [31:0] v;
    if (!is_al(a, sz)) return wmask(sz);
    w = eff_of(a) & 12'hFFC;
    case (w)
      12'h000: v = ctl_m;
      12'h004: v = stat_m();
      12'h00C: v = {28'b0, page_m};
      12'h010: v = codec_m;
      12'h020: v = sctl_m;
      default: v = ext_of(w)[5] ? ext_rdata : 32'hFFFF_FFFF;
    endcase
    return (v >> (8 * a[1:0])) & wmask(sz);
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] m;
    m = wmask(sz) << (8 * a[1:0]);
    return (o & ~m) | ((n << (8 * a[1:0])) & m);
  endfunction

  function automatic void m_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] ns;
    logic [31:0] pg;
    if (!is_al(a, sz)) return;
    case (eff_of(a) & 12'hFFC)
      12'h000: ctl_m = mrg(ctl_m, d, a, sz);
      12'h010: codec_m = mrg(codec_m, d, a, sz);
      12'h00C: begin pg = mrg({28'b0, page_m}, d, a, sz); page_m = pg[3:0]; end
      12'h020: begin
        ns = mrg(sctl_m, d, a, sz);
        for (int k = 0; k < 3; k++) if (sctl_m[8+k] && !ns[8+k]) pend_m[k] = 1'b0;
        sctl_m = ns;
      end
      default: ;
    endcase
  endfunction

  task automatic bus(input bit w, input logic [7:0] a, input logic [1:0] sz,
                     input logic [31:0] d, input logic [2:0] setm);
    logic [2:0] old_en, fell;
    @(negedge clk);
    req = 1; we = w; addr = a; size = sz; wdata = d; set_pend = setm;
    @(posedge clk);
    #1 req = 0; we = 0; set_pend = 0;
    old_en = sctl_m[10:8];
    if (w) m_wr(a, sz, d);
    fell = old_en & ~sctl_m[10:8];
    pend_m = pend_m | (setm & old_en & ~fell);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    bus(1, a, sz, d, 3'b000);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [1:0] sz);
    logic [5:0] e;
    @(negedge clk);
    req = 1; we = 0; addr = a; size = sz;
    #1;
    chk(tag, rdata, exp_rd(a, sz));
    e = ext_of(eff_of(a) & 12'hFFC);
    chk("R5 ext_rd", {31'b0, ext_rd}, {31'b0, e[5] & is_al(a, sz)});
    if (e[5] && is_al(a, sz)) chk("R5 sel", {27'b0, ext_chan, ext_field}, {27'b0, e[4:0]});
    @(posedge clk);
    #1 req = 0;
  endtask

  task automatic all_regs(input string tag);
    rd_chk(tag, 8'h00, 2); rd_chk(tag, 8'h04, 2); rd_chk(tag, 8'h0C, 2);
    rd_chk(tag, 8'h10, 2); rd_chk(tag, 8'h20, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    all_regs("R1");

    // R2/R3 lane merges with distinct patterns
    for (int l = 0; l < 4; l++) begin
      wr(8'h00 + l[7:0], 0, 32'h11 * (l + 1) ^ 32'h80);
      wr(8'h10 + l[7:0], 0, 32'h3C + l);
      wr(8'h20 + l[7:0], 0, 32'hC0 | l);
      all_regs("R2 byte");
      for (int a = 0; a < 4; a++) rd_chk("R3 byte", 8'h00 + a[7:0], 0);
    end
    wr(8'h02, 1, 32'hBEEF); wr(8'h10, 1, 32'h1234); wr(8'h22, 1, 32'h00F0);
    all_regs("R2 half");
    rd_chk("R3 half", 8'h00, 1); rd_chk("R3 half", 8'h02, 1);
    wr(8'h10, 2, 32'hDEAD_0001);
    all_regs("R2 word");

    // R6/R7 ignored writes
    wr(8'h04, 2, 32'hFFFF_FFFF); wr(8'h06, 1, 32'h1234);
    all_regs("R7");
    wr(8'h01, 1, 32'hFFFF); wr(8'h02, 2, 32'h0); wr(8'h08, 2, 32'h0); wr(8'h40, 2, 32'h0);
    all_regs("R6");

    // R4 page keeps low 4 bits
    wr(8'h0C, 2, 32'hFFFF_FFF7);
    rd_chk("R4 page", 8'h0C, 2);

    // R3/R4/R5/R6 exhaustive read sweep over pages
    for (int p = 0; p < 4; p++) begin
      wr(8'h0C, 2, (p == 0) ? 32'h0 : (p == 1) ? 32'h5 : (p == 2) ? 32'hC : 32'hD);
      for (int a = 0; a < 256; a++)
        for (int s = 0; s < 3; s++) rd_chk("R3/R4/R6 sweep", a[7:0], s[1:0]);
    end

    // R5 external write strobe
    wr(8'h0C, 2, 32'hC);
    @(negedge clk);
    req = 1; we = 1; addr = 8'h36; size = 1; wdata = 32'h00AB;
    #1;
    chk("R5 wr", {31'b0, ext_wr}, 32'h1);
    chk("R5 wsel", {27'b0, ext_chan, ext_field}, {27'b0, 3'b001, 2'd2});
    chk("R5 be", {28'b0, ext_be}, 32'hC);
    chk("R5 wdata", ext_wdata, 32'h00AB_0000);
    @(posedge clk); #1 req = 0; we = 0;
    @(negedge clk);
    req = 1; we = 1; addr = 8'h39; size = 1; wdata = 32'h1;
    #1 chk("R6 misaligned ext", {31'b0, ext_wr}, 32'h0);
    @(posedge clk); #1 req = 0; we = 0;

    // R8 gating
    wr(8'h20, 2, 32'h0);
    bus(0, 8'h00, 2, 0, 3'b111);
    rd_chk("R8 gated", 8'h04, 2);
    chk("R8 irq", {31'b0, irq}, 32'h0);
    wr(8'h20, 2, 32'h0000_0700);
    bus(0, 8'h00, 2, 0, 3'b010);
    rd_chk("R8/R9 one", 8'h04, 2);
    chk("R9 irq", {31'b0, irq}, 32'h1);
    bus(0, 8'h00, 2, 0, 3'b101);
    rd_chk("R9 all", 8'h04, 2);
    // R10 clear on falling enable via byte write
    wr(8'h21, 0, 32'h05);
    rd_chk("R10 clear", 8'h04, 2);
    // R10 clear beats set in same cycle
    wr(8'h21, 0, 32'h07);
    bus(1, 8'h21, 0, 32'h06, 3'b001);
    rd_chk("R10 priority", 8'h04, 2);
    wr(8'h21, 0, 32'h00);
    rd_chk("R10 all clear", 8'h04, 2);
    chk("R10 irq low", {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule